// File: doc/BRIEF.md
# Configurable Frame Serial Transmitter

This block turns characters into asynchronous serial frames on a single transmit line. Each frame has one low start bit, a character field sent least significant bit first, and one high stop bit. Three format inputs shape the frame.

- The first input picks a character of eight or nine bits.
- The second turns on parity. When parity is on, the parity bit takes over the top position of the character, so it does not lengthen the frame.
- The third picks odd or even parity.

A client hands over a byte and a ninth-bit value through a valid/ready handshake. The block then waits for the external baud tick and moves one bit position per tick. The line idles high. Ready returns only after the stop bit has been on the line for a full tick period.

The format inputs are sampled in the cycle a character is accepted. Changing them during a frame does not alter that frame. In nine-bit mode without parity, setting the ninth-bit input high makes that position look like a second stop bit.

Top module: `ser_frame_tx`

## Requirements
- R1: After reset, and whenever no frame is in progress, `txd` is 1 and `in_ready` is 1. Baud ticks while idle leave `txd` at 1.
- R2: A character is accepted on a rising clock edge where `in_valid` and `in_ready` are both 1. `in_ready` is 0 from the next cycle until the frame ends. `in_valid` asserted while busy has no effect on the frame being sent.
- R3: After acceptance, `txd` stays 1 until the first baud tick that comes after the accepting edge. That tick puts the start bit (0) on the line. Each later tick advances exactly one bit, and `txd` never changes on an edge without a tick.
- R4: With `cfg_nine`=0 and `cfg_par_en`=0, the frame is 10 bits: 0, then `in_data[0]` through `in_data[7]`, then 1.
- R5: With `cfg_nine`=1 and `cfg_par_en`=0, the frame is 11 bits: 0, then `in_data[0]` through `in_data[7]`, then `in_bit9`, then 1.
- R6: With `cfg_nine`=0 and `cfg_par_en`=1, the frame is 10 bits: 0, then `in_data[0]` through `in_data[6]`, then the parity bit, then 1. `in_data[7]` is not sent.
- R7: With `cfg_nine`=1 and `cfg_par_en`=1, the frame is 11 bits: 0, then `in_data[0]` through `in_data[7]`, then the parity bit, then 1. `in_bit9` is not sent.
- R8: When `cfg_par_odd`=1, the data bits plus the parity bit contain an odd number of ones. When `cfg_par_odd`=0, they contain an even number of ones.
- R9: The format inputs are captured at acceptance. Changing them while a frame is being sent does not change that frame.
- R10: The tick that ends the stop bit's period returns `in_ready` to 1, with `txd` at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| baud_tick | input | 1 | One-cycle pulse marking each bit period |
| cfg_nine | input | 1 | 1 = nine-bit character, 0 = eight-bit |
| cfg_par_en | input | 1 | 1 = parity replaces the top character bit |
| cfg_par_odd | input | 1 | 1 = odd parity, 0 = even parity |
| in_valid | input | 1 | Character offered |
| in_data | input | 8 | Character data, bit 0 sent first |
| in_bit9 | input | 1 | Ninth bit, used in nine-bit mode without parity |
| in_ready | output | 1 | Block can accept a character |
| txd | output | 1 | Serial output, idles high |

## Verification
Acceptance happens at a clock edge, and `in_ready` is expected to be low from the next cycle. Each frame bit is due on `txd` one cycle after the tick edge that launches it. Ready and the idle level are due one cycle after the tick that follows the last bit. The bench therefore waits for a rising edge that sees `baud_tick` high, then samples at the following falling edge, which is one register stage later. The expected frame is built from the format values held at acceptance, so format changes made afterwards (R9) and valid pulses offered while busy (R2) are measured against that same frame.

// File: rtl/ser_tx_pkg.sv
// Shared types for the serial frame transmitter.
package ser_tx_pkg;
    // Frame format selection as captured from the control inputs.
    typedef struct packed {
        logic nine;     // 1: nine-bit character
        logic par_en;   // 1: parity replaces the top character bit
        logic par_odd;  // 1: odd parity, 0: even parity
    } fmt_t;
endpackage

// File: rtl/ser_tx_framer.sv
// Builds the complete frame word (LSB is transmitted first) and its bit
// count from a character and a format. Purely combinational; assumes the
// caller loads the result only in the cycle the character is accepted.
module ser_tx_framer
    import ser_tx_pkg::*;
#(
    parameter int CHAR_W  = 8,
    parameter int FRAME_W = CHAR_W + 3,
    parameter int CNT_W   = $clog2(FRAME_W + 1)
) (
    input  logic [CHAR_W-1:0]  data,
    input  logic               bit9,
    input  fmt_t               fmt,
    output logic [FRAME_W-1:0] word,
    output logic [CNT_W-1:0]   len
);
    logic             par_short;   // parity over CHAR_W-1 data bits
    logic             par_long;    // parity over CHAR_W data bits
    logic [CHAR_W-1:0] low_field;  // bits 1..CHAR_W of the frame
    logic             top_bit;     // bit CHAR_W+1: ninth bit or stop

    // Parity of each possible data width, flipped for odd parity.
    always_comb begin
        par_short = (^data[CHAR_W-2:0]) ^ fmt.par_odd;
        par_long  = (^data) ^ fmt.par_odd;
    end

    // Select the character field contents for the chosen format.
    always_comb begin
        low_field = data;
        top_bit   = 1'b1;
        if (fmt.nine) begin
            top_bit = fmt.par_en ? par_long : bit9;
        end else if (fmt.par_en) begin
            low_field = {par_short, data[CHAR_W-2:0]};
        end
    end

    // Assemble start bit, character field, ninth/stop position, stop pad.
    always_comb begin
        word = {1'b1, top_bit, low_field, 1'b0};
        len  = fmt.nine ? CNT_W'(FRAME_W) : CNT_W'(FRAME_W - 1);
    end
endmodule

// File: rtl/ser_tx_seq.sv
// Frame sequencer: tracks whether a frame is in progress and how many bits
// have been launched. Assumes accept is only raised while idle.
module ser_tx_seq #(
    parameter int FRAME_W = 11,
    parameter int CNT_W   = $clog2(FRAME_W + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             accept,
    input  logic             tick,
    input  logic [CNT_W-1:0] len_in,
    output logic             busy,
    output logic             shift_en,
    output logic [CNT_W-1:0] bit_idx
);
    logic [CNT_W-1:0] len_q;

    // A tick launches the next bit until len_q bits are out.
    always_comb shift_en = busy && tick && (bit_idx != len_q);

    // Busy flag, bit counter and captured length.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy    <= 1'b0;
            bit_idx <= '0;
            len_q   <= '0;
        end else if (accept) begin
            busy    <= 1'b1;
            bit_idx <= '0;
            len_q   <= len_in;
        end else if (busy && tick) begin
            if (bit_idx == len_q) busy <= 1'b0;
            else                  bit_idx <= bit_idx + CNT_W'(1);
        end
    end

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (bit_idx <= len_q)) else $error("bit count past frame"); // R3
endmodule

// File: rtl/ser_tx_shift.sv
// Output shifter: holds the loaded frame and drives txd one bit per launch.
// Assumes load and shift are never raised in the same cycle.
module ser_tx_shift #(
    parameter int FRAME_W = 11
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load,
    input  logic [FRAME_W-1:0] word,
    input  logic               shift,
    input  logic               tick,
    output logic               txd
);
    logic [FRAME_W-1:0] sr;

    // Load a new frame, or move the next bit onto the line.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sr  <= '1;
            txd <= 1'b1;
        end else if (load) begin
            sr  <= word;
        end else if (shift) begin
            txd <= sr[0];
            sr  <= {1'b1, sr[FRAME_W-1:1]};
        end
    end

    AST_TXD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(txd)) else $error("txd moved without tick"); // R3
endmodule

// File: rtl/ser_frame_tx.sv
// Configurable-format asynchronous serial transmitter. Accepts a character
// through valid/ready, samples the format at acceptance and sends
// start, character field and stop bits, one per external baud tick.
// Assumes baud_tick is a single-cycle pulse synchronous to clk.
module ser_frame_tx
    import ser_tx_pkg::*;
#(
    parameter int CHAR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              baud_tick,
    input  logic              cfg_nine,
    input  logic              cfg_par_en,
    input  logic              cfg_par_odd,
    input  logic              in_valid,
    input  logic [CHAR_W-1:0] in_data,
    input  logic              in_bit9,
    output logic              in_ready,
    output logic              txd
);
    localparam int FRAME_W = CHAR_W + 3;
    localparam int CNT_W   = $clog2(FRAME_W + 1);

    fmt_t               fmt_now;
    logic [FRAME_W-1:0] word;
    logic [CNT_W-1:0]   len;
    logic               accept;
    logic               busy;
    logic               shift_en;
    logic [CNT_W-1:0]   bit_idx;

    // Gather format inputs and the handshake outcome.
    always_comb begin
        fmt_now  = '{nine: cfg_nine, par_en: cfg_par_en, par_odd: cfg_par_odd};
        in_ready = !busy;
        accept   = in_valid && in_ready;
    end

    ser_tx_framer #(.CHAR_W(CHAR_W), .FRAME_W(FRAME_W), .CNT_W(CNT_W)) u_framer (
        .data(in_data), .bit9(in_bit9), .fmt(fmt_now), .word(word), .len(len)
    );

    ser_tx_seq #(.FRAME_W(FRAME_W), .CNT_W(CNT_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .accept(accept), .tick(baud_tick),
        .len_in(len), .busy(busy), .shift_en(shift_en), .bit_idx(bit_idx)
    );

    ser_tx_shift #(.FRAME_W(FRAME_W)) u_shift (
        .clk(clk), .rst_n(rst_n), .load(accept), .word(word),
        .shift(shift_en), .tick(baud_tick), .txd(txd)
    );

    AST_IDLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready |-> txd) else $error("line low while idle"); // R1
    AST_ACCEPT_DROPS_READY: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> !in_ready) else $error("ready stayed high"); // R2
    AST_START_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && baud_tick && bit_idx == '0) |=> !txd) else $error("no start bit"); // R3
    AST_READY_AFTER_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(in_ready) |-> ($past(baud_tick) && txd)) else $error("bad frame end"); // R10
endmodule

// File: tb/ser_frame_tx_test.sv
module ser_frame_tx_test;
    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic baud_tick = 1'b0;
    logic cfg_nine = 1'b0, cfg_par_en = 1'b0, cfg_par_odd = 1'b0;
    logic in_valid = 1'b0;
    logic [7:0] in_data = '0;
    logic in_bit9 = 1'b0;
    logic in_ready, txd;

    int checks = 0;
    int fails = 0;
    int tick_div = 3;
    int tcnt = 0;
    bit done = 1'b0;

    ser_frame_tx uut (
        .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick),
        .cfg_nine(cfg_nine), .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd),
        .in_valid(in_valid), .in_data(in_data), .in_bit9(in_bit9),
        .in_ready(in_ready), .txd(txd)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Baud tick source: one-cycle pulse every tick_div cycles.
    initial begin
        forever begin
            @(negedge clk);
            baud_tick = (tcnt == 0);
            tcnt = (tcnt + 1) % tick_div;
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // Expected frame from the format requirements R4..R8.
    function automatic logic [10:0] exp_word(input logic [7:0] d, input logic b9,
                                             input logic nine, input logic pe, input logic odd);
        logic [10:0] w;
        logic p;
        w = '1;
        w[0] = 1'b0;
        if (!nine) begin
            w[8:1] = d;
            if (pe) begin
                p = odd ? ~(^d[6:0]) : (^d[6:0]);
                w[8] = p;
            end
        end else begin
            w[8:1] = d;
            w[9] = pe ? (odd ? ~(^d) : (^d)) : b9;
        end
        return w;
    endfunction

    task automatic wait_tick();
        do @(posedge clk); while (!baud_tick);
        @(negedge clk);
    endtask

    task automatic send(input logic [7:0] d, input logic b9, input logic nine,
                        input logic pe, input logic odd, input bit mid_change, input bit poke);
        logic [10:0] exp;
        logic [10:0] got;
        int n;
        string tag;
        exp = exp_word(d, b9, nine, pe, odd);
        n = nine ? 11 : 10;
        tag = mid_change ? "R9" : (poke ? "R2" : (nine ? (pe ? "R7" : "R5") : (pe ? "R6" : "R4")));
        got = '1;
        @(negedge clk);
        chk(in_ready == 1'b1, "R1 ready before send", int'(in_ready), 1);
        cfg_nine = nine; cfg_par_en = pe; cfg_par_odd = odd;
        in_data = d; in_bit9 = b9; in_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0;
        chk(in_ready == 1'b0, "R2 ready low after accept", int'(in_ready), 0);
        chk(txd == 1'b1, "R3 line high before first tick", int'(txd), 1);
        if (mid_change) begin
            cfg_nine = ~nine; cfg_par_en = ~pe; cfg_par_odd = ~odd;
            in_data = ~d; in_bit9 = ~b9;
        end
        for (int i = 0; i < n; i++) begin
            wait_tick();
            got[i] = txd;
            if (poke && i == 1) begin
                in_data = ~d; in_bit9 = ~b9; in_valid = 1'b1;
            end
            if (poke && i == n - 3) in_valid = 1'b0;
            if (in_ready !== 1'b0) chk(1'b0, "R2 ready high mid-frame", int'(in_ready), 0);
        end
        chk(got[0] == 1'b0, "R3 start bit", int'(got[0]), 0);
        chk(got == exp, tag, int'(got), int'(exp));
        if (pe) begin
            int ones;
            ones = nine ? $countones(got[9:1]) : $countones(got[8:1]);
            chk((ones % 2) == (odd ? 1 : 0), "R8 parity sense", ones % 2, odd ? 1 : 0);
        end
        wait_tick();
        chk(in_ready == 1'b1 && txd == 1'b1, "R10 ready and idle after stop",
            int'({in_ready, txd}), 3);
    endtask

    initial begin
        void'($urandom(32'd1234));
        repeat (4) @(posedge clk);
        @(negedge clk);
        chk(txd == 1'b1 && in_ready == 1'b1, "R1 reset state", int'({in_ready, txd}), 3);
        rst_n = 1'b1;
        repeat (8) @(negedge clk);
        chk(txd == 1'b1, "R1 idle ticks leave line high", int'(txd), 1);
        // Directed corner cases
        send(8'hA5, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
        send(8'h3C, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
        send(8'h3C, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
        send(8'hFF, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
        send(8'h80, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0);
        send(8'h01, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
        send(8'h00, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0);
        send(8'h5A, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0);
        send(8'hC3, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1);
        tick_div = 1;
        send(8'h96, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
        // Constrained random frames
        for (int k = 0; k < 40; k++) begin
            tick_div = 1 + ($urandom % 5);
            send(8'($urandom), 1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom),
                 ($urandom % 4) == 0, ($urandom % 4) == 0);
        end
        repeat (10) @(negedge clk);
        chk(txd == 1'b1 && in_ready == 1'b1, "R1 idle at end", int'({in_ready, txd}), 3);
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", checks - fails, checks);
        end
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
        end
        $finish;
    end
endmodule